// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a fully associative translation cache for a processor's memory pipeline. Each slot holds a virtual page tag, a physical page number, an address-space number, a global bit, a read-enable mask and a write-enable mask with one bit per privilege mode, and two fault-on-access bits, one for reads and one for writes. A lookup gives a virtual page number and the current address-space number. The result appears combinationally in the same cycle: hit, slot index, the stored fields, and flags for a multiple match and for a hit taken through the recent-entry shortcut. Fault decisions are left to downstream logic.

Software refills the buffer through an insert port. The insert port always writes the slot under a round-robin victim pointer. Three invalidate commands are provided: drop everything, drop all entries that are not global, and drop one page for one address space. A small shortcut remembers the slots that recently hit. It is searched before the full array, and any insert or flush empties it.

Top module: `tlb_asn_cam`

## Requirements
- R1: After reset no lookup hits, the shortcut is empty and the victim pointer is at slot 0.
- R2: A lookup hits only when a valid slot's tag equals the requested page and that slot's address-space number equals the requested one, or the slot is global. On a hit, lk_slot, lk_ppn, the mode masks and the fault bits come from that slot.
- R3: A global slot hits for any requested address-space number.
- R4: An insert writes the slot under the victim pointer, even if that slot is valid, marks it valid, and moves the pointer up by one.
- R5: The victim pointer wraps from slot DEPTH-1 to slot 0.
- R6: flush_cmd = 2'b01 invalidates every slot and returns the victim pointer to 0.
- R7: flush_cmd = 2'b10 invalidates every non-global slot, keeps global slots, and leaves the pointer unchanged.
- R8: flush_cmd = 2'b11 invalidates every valid slot whose tag equals flush_vpn and which is global or has address-space number flush_asn. Other slots and the pointer are unchanged.
- R9: A hit through the full array puts that slot at the front of a shortcut of FAST_SLOTS slots, so the next lookup of it raises lk_fast. When the shortcut is full, its oldest slot is dropped.
- R10: Any insert or flush empties the shortcut.
- R11: When several valid slots match, lk_multi is raised and, if the shortcut misses, the lowest-index match is returned.
- R12: A lookup in the same cycle as an insert or flush sees the table as it was before that operation.
- R13: When a flush command (flush_cmd not 2'b00) and an insert arrive in the same cycle, the flush is applied, the insert is dropped, and the pointer is not advanced by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page to look up |
| lk_asn | input | ASN_W | Current address-space number |
| ins_valid | input | 1 | Insert request |
| ins_vpn | input | VPN_W | Tag of new entry |
| ins_ppn | input | PPN_W | Physical page of new entry |
| ins_asn | input | ASN_W | Address-space number of new entry |
| ins_global | input | 1 | New entry matches every address space |
| ins_rd_en | input | MODES | Per-mode read enables |
| ins_wr_en | input | MODES | Per-mode write enables |
| ins_fault_rd | input | 1 | Fault-on-read bit |
| ins_fault_wr | input | 1 | Fault-on-write bit |
| flush_cmd | input | 2 | 00 none, 01 all, 10 non-global, 11 one page |
| flush_vpn | input | VPN_W | Page for the one-page flush |
| flush_asn | input | ASN_W | Address space for the one-page flush |
| lk_hit | output | 1 | Lookup hit |
| lk_fast | output | 1 | Hit came from the shortcut |
| lk_multi | output | 1 | More than one valid slot matched |
| lk_slot | output | IDX_W | Slot index of the hit |
| lk_ppn | output | PPN_W | Physical page of the hit (0 on miss) |
| lk_rd_en | output | MODES | Read enables of the hit |
| lk_wr_en | output | MODES | Write enables of the hit |
| lk_fault_rd | output | 1 | Fault-on-read bit of the hit |
| lk_fault_wr | output | 1 | Fault-on-write bit of the hit |

## Verification
The bench builds the block with DEPTH = 4 and a three-slot shortcut, and leaves the widths at their defaults. With four slots, the victim pointer wraps after a handful of inserts, so overwriting a live entry is easy to reach. Four distinct array hits then fill the shortcut and push out its oldest slot. The small table also makes it simple to place global and per-space entries on the same page for both the one-page flush and the multiple-match case.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // Invalidate commands carried on flush_cmd
    typedef enum logic [1:0] {
        FL_NONE  = 2'b00,
        FL_ALL   = 2'b01,
        FL_LOCAL = 2'b10,
        FL_PAGE  = 2'b11
    } flush_e;

endpackage

// File: rtl/tlb_match.sv
// Per-slot tag / address-space compare with lowest-index priority encode.
module tlb_match #(
    parameter int DEPTH = 8,
    parameter int VPN_W = 20,
    parameter int ASN_W = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0]            vld,
    input  logic [DEPTH-1:0][VPN_W-1:0] vpn,
    input  logic [DEPTH-1:0][ASN_W-1:0] asn,
    input  logic [DEPTH-1:0]            glb,
    input  logic [VPN_W-1:0]            req_vpn,
    input  logic [ASN_W-1:0]            req_asn,
    output logic [DEPTH-1:0]            hit_vec,
    output logic                        any,
    output logic [IDX_W-1:0]            first_idx,
    output logic                        multi
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_vec[g] = vld[g] && (vpn[g] == req_vpn) &&
                            (glb[g] || (asn[g] == req_asn));
    end

    always_comb begin
        first_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hit_vec[i]) first_idx = IDX_W'(i);
        end
    end

    assign any   = |hit_vec;
    assign multi = ($countones(hit_vec) > 1);

endmodule

// File: rtl/tlb_store.sv
// Entry storage, victim pointer, insert and the three invalidate rules.
module tlb_store #(
    parameter int DEPTH = 8,
    parameter int VPN_W = 20,
    parameter int PPN_W = 16,
    parameter int ASN_W = 8,
    parameter int MODES = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ins_valid,
    input  logic [VPN_W-1:0]            ins_vpn,
    input  logic [PPN_W-1:0]            ins_ppn,
    input  logic [ASN_W-1:0]            ins_asn,
    input  logic                        ins_glb,
    input  logic [MODES-1:0]            ins_rd,
    input  logic [MODES-1:0]            ins_wr,
    input  logic                        ins_frd,
    input  logic                        ins_fwr,
    input  tlb_pkg::flush_e             flush_cmd,
    input  logic [DEPTH-1:0]            page_sel,
    output logic [DEPTH-1:0]            e_vld,
    output logic [DEPTH-1:0][VPN_W-1:0] e_vpn,
    output logic [DEPTH-1:0][PPN_W-1:0] e_ppn,
    output logic [DEPTH-1:0][ASN_W-1:0] e_asn,
    output logic [DEPTH-1:0]            e_glb,
    output logic [DEPTH-1:0][MODES-1:0] e_rd,
    output logic [DEPTH-1:0][MODES-1:0] e_wr,
    output logic [DEPTH-1:0]            e_frd,
    output logic [DEPTH-1:0]            e_fwr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0]            vld;
        logic [DEPTH-1:0][VPN_W-1:0] vpn;
        logic [DEPTH-1:0][PPN_W-1:0] ppn;
        logic [DEPTH-1:0][ASN_W-1:0] asn;
        logic [DEPTH-1:0]            glb;
        logic [DEPTH-1:0][MODES-1:0] rd;
        logic [DEPTH-1:0][MODES-1:0] wr;
        logic [DEPTH-1:0]            frd;
        logic [DEPTH-1:0]            fwr;
        logic [IDX_W-1:0]            ptr;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (flush_cmd)
            tlb_pkg::FL_ALL: begin
                st_d.vld = '0;
                st_d.ptr = '0;
            end
            tlb_pkg::FL_LOCAL: st_d.vld = st_q.vld & st_q.glb;
            tlb_pkg::FL_PAGE:  st_d.vld = st_q.vld & ~page_sel;
            default: begin
                if (ins_valid) begin
                    st_d.vld[st_q.ptr] = 1'b1;
                    st_d.vpn[st_q.ptr] = ins_vpn;
                    st_d.ppn[st_q.ptr] = ins_ppn;
                    st_d.asn[st_q.ptr] = ins_asn;
                    st_d.glb[st_q.ptr] = ins_glb;
                    st_d.rd[st_q.ptr]  = ins_rd;
                    st_d.wr[st_q.ptr]  = ins_wr;
                    st_d.frd[st_q.ptr] = ins_frd;
                    st_d.fwr[st_q.ptr] = ins_fwr;
                    st_d.ptr = (st_q.ptr == LAST) ? '0 : st_q.ptr + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign e_vld = st_q.vld;
    assign e_vpn = st_q.vpn;
    assign e_ppn = st_q.ppn;
    assign e_asn = st_q.asn;
    assign e_glb = st_q.glb;
    assign e_rd  = st_q.rd;
    assign e_wr  = st_q.wr;
    assign e_frd = st_q.frd;
    assign e_fwr = st_q.fwr;

    assert_insert_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && flush_cmd == tlb_pkg::FL_NONE && st_q.ptr != LAST)
        |=> (st_q.ptr == $past(st_q.ptr) + 1'b1) && st_q.vld[$past(st_q.ptr)]);

    assert_ptr_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && flush_cmd == tlb_pkg::FL_NONE && st_q.ptr == LAST)
        |=> (st_q.ptr == '0) && st_q.vld[DEPTH-1]);

    assert_flush_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_cmd == tlb_pkg::FL_ALL) |=> (st_q.vld == '0) && (st_q.ptr == '0));

    assert_flush_local_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_cmd == tlb_pkg::FL_LOCAL)
        |=> ((st_q.vld & ~st_q.glb) == '0) && (st_q.ptr == $past(st_q.ptr))
            && ((st_q.vld & st_q.glb) == ($past(st_q.vld) & st_q.glb)));

    assert_flush_page_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_cmd == tlb_pkg::FL_PAGE)
        |=> ((st_q.vld & $past(page_sel)) == '0) && (st_q.ptr == $past(st_q.ptr)));

    assert_flush_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && (flush_cmd == tlb_pkg::FL_LOCAL || flush_cmd == tlb_pkg::FL_PAGE))
        |=> (st_q.ptr == $past(st_q.ptr)));

endmodule

// File: rtl/tlb_recent.sv
// Most-recently-hit slot shortcut, searched ahead of the full priority result.
module tlb_recent #(
    parameter int DEPTH = 8,
    parameter int SLOTS = 3,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             lookup,
    input  logic             arr_any,
    input  logic [IDX_W-1:0] arr_idx,
    input  logic [DEPTH-1:0] hit_vec,
    output logic             fast_hit,
    output logic [IDX_W-1:0] fast_idx
);

    typedef struct packed {
        logic [SLOTS-1:0]            vld;
        logic [SLOTS-1:0][IDX_W-1:0] idx;
    } recent_t;

    recent_t rc_d, rc_q;

    always_comb begin
        fast_hit = 1'b0;
        fast_idx = '0;
        for (int s = SLOTS - 1; s >= 0; s--) begin
            if (rc_q.vld[s] && hit_vec[rc_q.idx[s]]) begin
                fast_hit = 1'b1;
                fast_idx = rc_q.idx[s];
            end
        end
    end

    always_comb begin
        rc_d = rc_q;
        if (clear) begin
            rc_d.vld = '0;
        end else if (lookup && arr_any && !fast_hit) begin
            for (int s = SLOTS - 1; s >= 1; s--) begin
                rc_d.vld[s] = rc_q.vld[s-1];
                rc_d.idx[s] = rc_q.idx[s-1];
            end
            rc_d.vld[0] = 1'b1;
            rc_d.idx[0] = arr_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rc_q <= '0;
        else        rc_q <= rc_d;
    end

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (rc_q.vld == '0));

    assert_install_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup && arr_any && !fast_hit && !clear)
        |=> rc_q.vld[0] && (rc_q.idx[0] == $past(arr_idx)));

    assert_fast_implies_array_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fast_hit |-> arr_any);

endmodule

// File: rtl/tlb_asn_cam.sv
module tlb_asn_cam #(
    parameter int DEPTH      = 8,
    parameter int FAST_SLOTS = 3,
    parameter int VPN_W      = 20,
    parameter int PPN_W      = 16,
    parameter int ASN_W      = 8,
    parameter int MODES      = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [ASN_W-1:0] lk_asn,
    input  logic             ins_valid,
    input  logic [VPN_W-1:0] ins_vpn,
    input  logic [PPN_W-1:0] ins_ppn,
    input  logic [ASN_W-1:0] ins_asn,
    input  logic             ins_global,
    input  logic [MODES-1:0] ins_rd_en,
    input  logic [MODES-1:0] ins_wr_en,
    input  logic             ins_fault_rd,
    input  logic             ins_fault_wr,
    input  logic [1:0]       flush_cmd,
    input  logic [VPN_W-1:0] flush_vpn,
    input  logic [ASN_W-1:0] flush_asn,
    output logic             lk_hit,
    output logic             lk_fast,
    output logic             lk_multi,
    output logic [IDX_W-1:0] lk_slot,
    output logic [PPN_W-1:0] lk_ppn,
    output logic [MODES-1:0] lk_rd_en,
    output logic [MODES-1:0] lk_wr_en,
    output logic             lk_fault_rd,
    output logic             lk_fault_wr
);

    tlb_pkg::flush_e fl_cmd;
    assign fl_cmd = tlb_pkg::flush_e'(flush_cmd);

    logic [DEPTH-1:0]            e_vld, e_glb, e_frd, e_fwr;
    logic [DEPTH-1:0][VPN_W-1:0] e_vpn;
    logic [DEPTH-1:0][PPN_W-1:0] e_ppn;
    logic [DEPTH-1:0][ASN_W-1:0] e_asn;
    logic [DEPTH-1:0][MODES-1:0] e_rd, e_wr;

    logic [DEPTH-1:0] lk_vec, fl_vec;
    logic             lk_any, fl_any, lk_mh, fl_mh;
    logic [IDX_W-1:0] lk_first, fl_first;
    logic             fast_hit;
    logic [IDX_W-1:0] fast_idx;
    logic             sc_clear;

    tlb_match #(.DEPTH(DEPTH), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_lk_match (
        .vld(e_vld), .vpn(e_vpn), .asn(e_asn), .glb(e_glb),
        .req_vpn(lk_vpn), .req_asn(lk_asn),
        .hit_vec(lk_vec), .any(lk_any), .first_idx(lk_first), .multi(lk_mh)
    );

    tlb_match #(.DEPTH(DEPTH), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_fl_match (
        .vld(e_vld), .vpn(e_vpn), .asn(e_asn), .glb(e_glb),
        .req_vpn(flush_vpn), .req_asn(flush_asn),
        .hit_vec(fl_vec), .any(fl_any), .first_idx(fl_first), .multi(fl_mh)
    );

    tlb_store #(.DEPTH(DEPTH), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASN_W(ASN_W),
                .MODES(MODES)) u_store (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_vpn(ins_vpn), .ins_ppn(ins_ppn),
        .ins_asn(ins_asn), .ins_glb(ins_global), .ins_rd(ins_rd_en),
        .ins_wr(ins_wr_en), .ins_frd(ins_fault_rd), .ins_fwr(ins_fault_wr),
        .flush_cmd(fl_cmd), .page_sel(fl_vec),
        .e_vld(e_vld), .e_vpn(e_vpn), .e_ppn(e_ppn), .e_asn(e_asn),
        .e_glb(e_glb), .e_rd(e_rd), .e_wr(e_wr), .e_frd(e_frd), .e_fwr(e_fwr)
    );

    assign sc_clear = ins_valid || (fl_cmd != tlb_pkg::FL_NONE);

    tlb_recent #(.DEPTH(DEPTH), .SLOTS(FAST_SLOTS)) u_recent (
        .clk(clk), .rst_n(rst_n), .clear(sc_clear), .lookup(lk_valid),
        .arr_any(lk_any), .arr_idx(lk_first), .hit_vec(lk_vec),
        .fast_hit(fast_hit), .fast_idx(fast_idx)
    );

    always_comb begin
        lk_hit      = lk_valid && lk_any;
        lk_fast     = lk_valid && fast_hit;
        lk_multi    = lk_valid && lk_mh;
        lk_slot     = fast_hit ? fast_idx : lk_first;
        lk_ppn      = '0;
        lk_rd_en    = '0;
        lk_wr_en    = '0;
        lk_fault_rd = 1'b0;
        lk_fault_wr = 1'b0;
        if (lk_hit) begin
            lk_ppn      = e_ppn[lk_slot];
            lk_rd_en    = e_rd[lk_slot];
            lk_wr_en    = e_wr[lk_slot];
            lk_fault_rd = e_frd[lk_slot];
            lk_fault_wr = e_fwr[lk_slot];
        end
    end

    assert_hit_rule_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> e_vld[lk_slot] && (e_vpn[lk_slot] == lk_vpn) &&
                   (e_glb[lk_slot] || (e_asn[lk_slot] == lk_asn)));

    assert_multi_needs_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        lk_multi |-> lk_hit);

    assert_page_flush_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_cmd == tlb_pkg::FL_PAGE && fl_any) |=> !e_vld[$past(fl_first)]);

    assert_page_multi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fl_mh |-> fl_any);

endmodule

// File: tb/test_tlb_asn_cam.sv
module test_tlb_asn_cam;

    localparam int DEPTH = 4;
    localparam int FAST  = 3;
    localparam int VPN_W = 20;
    localparam int PPN_W = 16;
    localparam int ASN_W = 8;
    localparam int MODES = 4;
    localparam int IDX_W = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst_n;
    logic             lk_valid;
    logic [VPN_W-1:0] lk_vpn;
    logic [ASN_W-1:0] lk_asn;
    logic             ins_valid;
    logic [VPN_W-1:0] ins_vpn;
    logic [PPN_W-1:0] ins_ppn;
    logic [ASN_W-1:0] ins_asn;
    logic             ins_global;
    logic [MODES-1:0] ins_rd_en, ins_wr_en;
    logic             ins_fault_rd, ins_fault_wr;
    logic [1:0]       flush_cmd;
    logic [VPN_W-1:0] flush_vpn;
    logic [ASN_W-1:0] flush_asn;
    logic             lk_hit, lk_fast, lk_multi;
    logic [IDX_W-1:0] lk_slot;
    logic [PPN_W-1:0] lk_ppn;
    logic [MODES-1:0] lk_rd_en, lk_wr_en;
    logic             lk_fault_rd, lk_fault_wr;

    tlb_asn_cam #(.DEPTH(DEPTH), .FAST_SLOTS(FAST), .VPN_W(VPN_W), .PPN_W(PPN_W),
                  .ASN_W(ASN_W), .MODES(MODES)) i_tlb_asn_cam (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
        .lk_asn(lk_asn), .ins_valid(ins_valid), .ins_vpn(ins_vpn),
        .ins_ppn(ins_ppn), .ins_asn(ins_asn), .ins_global(ins_global),
        .ins_rd_en(ins_rd_en), .ins_wr_en(ins_wr_en),
        .ins_fault_rd(ins_fault_rd), .ins_fault_wr(ins_fault_wr),
        .flush_cmd(flush_cmd), .flush_vpn(flush_vpn), .flush_asn(flush_asn),
        .lk_hit(lk_hit), .lk_fast(lk_fast), .lk_multi(lk_multi),
        .lk_slot(lk_slot), .lk_ppn(lk_ppn), .lk_rd_en(lk_rd_en),
        .lk_wr_en(lk_wr_en), .lk_fault_rd(lk_fault_rd), .lk_fault_wr(lk_fault_wr)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        lk_valid = 0; lk_vpn = '0; lk_asn = '0;
        ins_valid = 0; ins_vpn = '0; ins_ppn = '0; ins_asn = '0; ins_global = 0;
        ins_rd_en = '0; ins_wr_en = '0; ins_fault_rd = 0; ins_fault_wr = 0;
        flush_cmd = 2'b00; flush_vpn = '0; flush_asn = '0;
    endtask

    task automatic set_ins(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p,
                           input logic [ASN_W-1:0] a, input logic g);
        ins_valid = 1; ins_vpn = v; ins_ppn = p; ins_asn = a; ins_global = g;
        ins_rd_en = 4'b1111; ins_wr_en = 4'b0001; ins_fault_rd = 0; ins_fault_wr = 0;
    endtask

    task automatic do_ins(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p,
                          input logic [ASN_W-1:0] a, input logic g);
        @(negedge clk);
        set_ins(v, p, a, g);
        @(posedge clk); #1;
        idle();
    endtask

    task automatic do_flush(input logic [1:0] c, input logic [VPN_W-1:0] v,
                            input logic [ASN_W-1:0] a);
        @(negedge clk);
        flush_cmd = c; flush_vpn = v; flush_asn = a;
        @(posedge clk); #1;
        idle();
    endtask

    // Lookup with expected hit, slot and shortcut flag (slot/fast checked on hits only)
    task automatic do_lk(input string req, input logic [VPN_W-1:0] v,
                         input logic [ASN_W-1:0] a, input logic eh,
                         input logic [IDX_W-1:0] es, input logic ef);
        @(negedge clk);
        lk_valid = 1; lk_vpn = v; lk_asn = a;
        #1;
        chk(req, "hit", 64'(lk_hit), 64'(eh));
        if (eh) begin
            chk(req, "slot", 64'(lk_slot), 64'(es));
            chk(req, "fast", 64'(lk_fast), 64'(ef));
        end
        @(posedge clk); #1;
        idle();
    endtask

    task automatic test_reset();
        do_lk("R1", 20'h00000, 8'h00, 0, 0, 0);
        do_lk("R1", 20'h12345, 8'h03, 0, 0, 0);
        chk("R1", "multi", 64'(lk_multi), 64'd0);
    endtask

    task automatic test_basic();
        @(negedge clk);
        ins_valid = 1; ins_vpn = 20'h12345; ins_ppn = 16'hABCD; ins_asn = 8'h03;
        ins_global = 0; ins_rd_en = 4'b0011; ins_wr_en = 4'b0001;
        ins_fault_rd = 0; ins_fault_wr = 1;
        @(posedge clk); #1;
        idle();
        @(negedge clk);
        lk_valid = 1; lk_vpn = 20'h12345; lk_asn = 8'h03;
        #1;
        chk("R2", "hit", 64'(lk_hit), 64'd1);
        chk("R4", "slot", 64'(lk_slot), 64'd0);
        chk("R2", "ppn", 64'(lk_ppn), 64'hABCD);
        chk("R2", "rd_en", 64'(lk_rd_en), 64'h3);
        chk("R2", "wr_en", 64'(lk_wr_en), 64'h1);
        chk("R2", "fault_rd", 64'(lk_fault_rd), 64'd0);
        chk("R2", "fault_wr", 64'(lk_fault_wr), 64'd1);
        chk("R9", "fast", 64'(lk_fast), 64'd0);
        @(posedge clk); #1;
        idle();
        do_lk("R2", 20'h12345, 8'h04, 0, 0, 0);
        do_lk("R2", 20'h12344, 8'h03, 0, 0, 0);
    endtask

    task automatic test_global();
        do_ins(20'h00777, 16'h0055, 8'h09, 1);           // slot 1
        do_lk("R3", 20'h00777, 8'h01, 1, 1, 0);
        do_lk("R3", 20'h00777, 8'h09, 1, 1, 1);
    endtask

    task automatic test_shortcut();
        do_lk("R9", 20'h12345, 8'h03, 1, 0, 0);
        do_lk("R9", 20'h12345, 8'h03, 1, 0, 1);
        do_flush(2'b11, 20'h99999, 8'h00);               // no slot matches
        do_lk("R10", 20'h12345, 8'h03, 1, 0, 0);
        do_ins(20'h00300, 16'h0300, 8'h03, 0);           // slot 2
        do_ins(20'h00301, 16'h0301, 8'h03, 0);           // slot 3, pointer wraps
        do_lk("R10", 20'h12345, 8'h03, 1, 0, 0);
        do_lk("R9", 20'h00777, 8'h03, 1, 1, 0);
        do_lk("R9", 20'h00300, 8'h03, 1, 2, 0);
        do_lk("R9", 20'h00301, 8'h03, 1, 3, 0);
        do_lk("R9", 20'h00777, 8'h03, 1, 1, 1);
        do_lk("R9", 20'h12345, 8'h03, 1, 0, 0);           // oldest evicted
    endtask

    task automatic test_replace();
        do_ins(20'h00400, 16'h0400, 8'h03, 0);           // wraps onto slot 0
        do_lk("R5", 20'h00400, 8'h03, 1, 0, 0);
        do_lk("R4", 20'h12345, 8'h03, 0, 0, 0);
    endtask

    task automatic test_flush_local();
        do_flush(2'b10, '0, '0);
        do_lk("R7", 20'h00777, 8'h01, 1, 1, 0);
        do_lk("R7", 20'h00400, 8'h03, 0, 0, 0);
        do_lk("R7", 20'h00300, 8'h03, 0, 0, 0);
        do_ins(20'h00500, 16'h0500, 8'h02, 0);           // pointer still 1
        do_lk("R7", 20'h00500, 8'h02, 1, 1, 0);
        do_lk("R4", 20'h00777, 8'h01, 0, 0, 0);
    endtask

    task automatic test_flush_page();
        do_ins(20'h00600, 16'h0602, 8'h01, 0);           // slot 2
        do_ins(20'h00600, 16'h0603, 8'h02, 0);           // slot 3
        do_ins(20'h00601, 16'h0610, 8'h01, 0);           // slot 0
        do_ins(20'h00600, 16'h0601, 8'h07, 1);           // slot 1, global
        do_flush(2'b11, 20'h00600, 8'h01);
        do_lk("R8", 20'h00600, 8'h02, 1, 3, 0);
        do_lk("R8", 20'h00600, 8'h01, 0, 0, 0);
        do_lk("R8", 20'h00601, 8'h01, 1, 0, 0);
        do_lk("R8", 20'h00600, 8'h05, 0, 0, 0);
        do_ins(20'h00700, 16'h0700, 8'h01, 0);           // pointer still 2
        do_lk("R8", 20'h00700, 8'h01, 1, 2, 0);
    endtask

    task automatic test_multi();
        do_ins(20'h00800, 16'h0803, 8'h05, 0);           // slot 3
        do_ins(20'h00800, 16'h0800, 8'h00, 1);           // slot 0, global
        @(negedge clk);
        lk_valid = 1; lk_vpn = 20'h00800; lk_asn = 8'h05;
        #1;
        chk("R11", "multi", 64'(lk_multi), 64'd1);
        chk("R11", "slot", 64'(lk_slot), 64'd0);
        chk("R11", "ppn", 64'(lk_ppn), 64'h0800);
        @(posedge clk); #1;
        idle();
        @(negedge clk);
        lk_valid = 1; lk_vpn = 20'h00800; lk_asn = 8'h06;
        #1;
        chk("R11", "single multi", 64'(lk_multi), 64'd0);
        chk("R11", "single slot", 64'(lk_slot), 64'd0);
        @(posedge clk); #1;
        idle();
    endtask

    task automatic test_same_cycle();
        @(negedge clk);
        set_ins(20'h00900, 16'h0900, 8'h01, 0);          // slot 1
        lk_valid = 1; lk_vpn = 20'h00900; lk_asn = 8'h01;
        #1;
        chk("R12", "hit during insert", 64'(lk_hit), 64'd0);
        @(posedge clk); #1;
        idle();
        do_lk("R12", 20'h00900, 8'h01, 1, 1, 0);
        @(negedge clk);
        flush_cmd = 2'b01;
        lk_valid = 1; lk_vpn = 20'h00900; lk_asn = 8'h01;
        #1;
        chk("R12", "hit during flush", 64'(lk_hit), 64'd1);
        chk("R12", "slot during flush", 64'(lk_slot), 64'd1);
        @(posedge clk); #1;
        idle();
        do_lk("R6", 20'h00900, 8'h01, 0, 0, 0);
        do_lk("R6", 20'h00800, 8'h06, 0, 0, 0);
        do_ins(20'h00A00, 16'h0A00, 8'h01, 0);
        do_lk("R6", 20'h00A00, 8'h01, 1, 0, 0);
    endtask

    task automatic test_flush_insert();
        @(negedge clk);
        flush_cmd = 2'b10;
        set_ins(20'h00B00, 16'h0B00, 8'h01, 0);
        @(posedge clk); #1;
        idle();
        do_lk("R13", 20'h00B00, 8'h01, 0, 0, 0);
        do_lk("R13", 20'h00A00, 8'h01, 0, 0, 0);
        do_ins(20'h00C00, 16'h0C00, 8'h01, 0);           // pointer still 1
        do_lk("R13", 20'h00C00, 8'h01, 1, 1, 0);
    endtask

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        test_reset();
        test_basic();
        test_global();
        test_shortcut();
        test_replace();
        test_flush_local();
        test_flush_page();
        test_multi();
        test_same_cycle();
        test_flush_insert();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule